// File: doc/BRIEF.md
# Synchronous Burst Read Engine

This block is the read path of a NOR-style memory running in synchronous burst mode. A host opens a burst by holding chip enable low and pulsing the address-valid strobe low across one rising clock edge. On that edge the engine takes the start address and the current configuration. It then counts a programmable number of latency cycles and streams one word per clock from an internal behavioural array.

Two address orders are available. In linear order the address counts upward through the whole array. In wrap order it circulates inside the aligned group of eight words that holds the start address. A ready output marks each cycle that carries a new word. In linear order, the step onto any address that is a multiple of 64 costs two extra cycles, and ready stays low for both of them.

The data path is the core side of a pad. It has a data word and a drive enable, and a low enable means the pad is high-impedance. Raising chip enable aborts the burst. A fresh address-valid pulse restarts the burst at any time.

Top module: `burst_read_engine`

## Requirements
- R1: The latency L equals `cfg_lat` (3 bits), except that values 0 and 1 act as 2. Count the capture edge as edge 0. The first word appears after edge L, so it is never visible sooner than two edges after capture.
- R2: From the capture edge until the first word appears, `rdy` is 0 and `data_en` is 0.
- R3: With `cfg_wrap`=0 (linear), each clock presents the word at the next address up. After the last array address the address rolls over to 0.
- R4: With `cfg_wrap`=1, the address increments only its three low bits and keeps the upper bits. For example, a start at offset 6 of a group gives offsets 6,7,0,1,2,3,4,5,6.
- R5: In linear order, when the next address has its six low bits all zero, two cycles are inserted before that word. In those cycles `rdy` is 0, `data_en` stays 1 and `data_out` holds the previous word.
- R6: Wrap order never inserts stall cycles.
- R7: `cfg_lat`, `cfg_wrap` and `cfg_rdy_en` are sampled only on the capture edge. Changing them during a burst has no effect on that burst.
- R8: A rising edge with `ce_n`=1 ends any burst. From the next cycle `rdy` and `data_en` are 0, and they stay 0 until a new capture.
- R9: A capture during a burst drops the old burst. It then restarts the latency count from the new address.
- R10: While `oe_n`=1, `data_en` is 0 at once, with no clock edge needed. The burst keeps advancing and `rdy` is not affected.
- R11: With `cfg_rdy_en`=0 captured, `rdy` stays 0 for the whole burst, while the data is still presented.
- R12: The word stored at address a is the low 16 bits of a*40503, XOR 0x5A5A.
- R13: After reset, `rdy` and `data_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| adv_n | input | 1 | Address-valid strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 10 | Start address of a burst |
| cfg_lat | input | 3 | Initial latency in cycles (2..7) |
| cfg_wrap | input | 1 | 1 = wrap inside 8-word group, 0 = linear |
| cfg_rdy_en | input | 1 | 1 = drive ready with the data |
| data_out | output | 16 | Word presented to the pad |
| data_en | output | 1 | Pad drive enable, 0 = high-impedance |
| rdy | output | 1 | High in each cycle that carries a new word |

## Verification
Counting the capture edge as edge 0, the first word and a high `rdy` are due just after edge L. After that, one word is due after each later edge, except that each 64-word crossing delays the next word by two edges. An abort shows after the very edge that samples `ce_n` high, while `oe_n` gates `data_en` with no edge at all. The bench drives and samples on falling edges. For every cycle after capture it works out the expected `rdy`, `data_en` and word from its own model of the latency, the address order and the stall rules, so that each check lands exactly in the cycle the result is due.

// File: rtl/bre_pkg.sv
// Package: shared state type for the burst read engine.
// Assumes: a four-state sequencer is enough for latency, streaming and stalls.
package bre_pkg;

    // Sequencer states of the burst controller
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WAIT   = 2'd1,
        ST_STREAM = 2'd2,
        ST_STALL  = 2'd3
    } bre_state_e;

endpackage

// File: rtl/bre_ctrl.sv
// Module: bre_ctrl
// Sequences one burst. It captures the configuration on the address-valid
// edge, counts the initial latency, issues one emit per word and inserts the
// boundary stall. Assumes inputs are synchronous to clk and that the address
// generator flags a boundary for the address following the one being emitted.
module bre_ctrl
    import bre_pkg::*;
#(
    parameter int LAT_W     = 3,
    parameter int MIN_LAT   = 2,
    parameter int STALL_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce_n,
    input  logic             adv_n,
    input  logic [LAT_W-1:0] cfg_lat,
    input  logic             cfg_wrap,
    input  logic             cfg_rdy_en,
    input  logic             bnd_next,
    output logic             capture,
    output logic             emit,
    output logic             wrap_q,
    output logic             rdy_en_q,
    output logic             valid_q,
    output logic             drive_q
);

    localparam int STL_W = $clog2(STALL_CYC + 1);
    localparam int CNT_W = (LAT_W > STL_W) ? LAT_W : STL_W;

    bre_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lat_eff;

    // Clamp the requested latency to the supported minimum
    always_comb begin
        if (cfg_lat < LAT_W'(MIN_LAT))
            lat_eff = CNT_W'(MIN_LAT);
        else
            lat_eff = CNT_W'(cfg_lat);
    end

    // Decode capture and word-emit strobes for this cycle
    always_comb begin
        capture = !ce_n && !adv_n;
        emit    = !ce_n && adv_n &&
                  ((state_q == ST_STREAM) ||
                   (((state_q == ST_WAIT) || (state_q == ST_STALL)) && (cnt_q == '0)));
    end

    // Advance the burst sequencer and its ready/drive registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cnt_q    <= '0;
            valid_q  <= 1'b0;
            drive_q  <= 1'b0;
            wrap_q   <= 1'b0;
            rdy_en_q <= 1'b0;
        end else if (ce_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            valid_q <= 1'b0;
            drive_q <= 1'b0;
        end else if (!adv_n) begin
            state_q  <= ST_WAIT;
            cnt_q    <= lat_eff - CNT_W'(1);
            wrap_q   <= cfg_wrap;
            rdy_en_q <= cfg_rdy_en;
            valid_q  <= 1'b0;
            drive_q  <= 1'b0;
        end else if (emit) begin
            valid_q <= 1'b1;
            drive_q <= 1'b1;
            if (bnd_next) begin
                state_q <= ST_STALL;
                cnt_q   <= CNT_W'(STALL_CYC);
            end else begin
                state_q <= ST_STREAM;
            end
        end else if ((state_q == ST_WAIT) || (state_q == ST_STALL)) begin
            cnt_q   <= cnt_q - CNT_W'(1);
            valid_q <= 1'b0;
        end
    end

    AST_MIN_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> !emit);                                               // R1
    AST_CAPTURE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (!valid_q && !drive_q));                              // R2
    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> ((state_q == ST_IDLE) && !valid_q && !drive_q));         // R8
    AST_WRAP_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_q |-> (state_q != ST_STALL));                                // R6

endmodule

// File: rtl/bre_addr_gen.sv
// Module: bre_addr_gen
// Holds the word pointer of the current burst. It loads the pointer on
// capture, steps it on each emit in linear or group-wrap order, and flags
// when the following linear address lands on a stall boundary. Assumes
// capture and emit never occur in the same cycle.
module bre_addr_gen #(
    parameter int AW       = 10,
    parameter int GRP_BITS = 3,
    parameter int BND_BITS = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic          emit,
    input  logic          wrap_q,
    input  logic [AW-1:0] addr,
    output logic [AW-1:0] ptr,
    output logic          bnd_next
);

    logic [AW-1:0] nxt_lin;
    logic [AW-1:0] nxt_wrp;
    logic [AW-1:0] nxt;

    // Form both successor addresses and pick one by the captured mode
    always_comb begin
        nxt_lin = ptr + AW'(1);
        nxt_wrp = {ptr[AW-1:GRP_BITS], ptr[GRP_BITS-1:0] + GRP_BITS'(1)};
        nxt     = wrap_q ? nxt_wrp : nxt_lin;
    end

    // Flag a linear step onto a boundary-aligned address
    always_comb begin
        bnd_next = !wrap_q && (nxt_lin[BND_BITS-1:0] == '0);
    end

    // Load or advance the word pointer
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (capture)
            ptr <= addr;
        else if (emit)
            ptr <= nxt;
    end

    AST_LIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (emit && !wrap_q) |=> (ptr == AW'($past(ptr) + AW'(1))));          // R3
    AST_WRAP_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        (emit && wrap_q) |=> (ptr[AW-1:GRP_BITS] == $past(ptr[AW-1:GRP_BITS]))); // R4

endmodule

// File: rtl/bre_array.sv
// Module: bre_array
// Behavioural read-only word store. Each word is a fixed scramble of its
// address, so no storage is instantiated. Assumes AW and DW do not exceed 32.
module bre_array #(
    parameter int          AW   = 10,
    parameter int          DW   = 16,
    parameter int unsigned MULT = 40503,
    parameter int unsigned SALT = 32'h5A5A
) (
    input  logic [AW-1:0] addr,
    output logic [DW-1:0] word
);

    logic [31:0] prod;

    // Compute the stored content for the addressed location
    always_comb begin
        prod = 32'(addr) * MULT;
        word = prod[DW-1:0] ^ SALT[DW-1:0];
    end

endmodule

// File: rtl/burst_read_engine.sv
// Module: burst_read_engine
// Top of the synchronous burst read path. It joins the sequencer, the address
// generator and the word store, registers the outgoing word and gates the pad
// drive enable with output and chip enable. Assumes a pad cell outside this
// block turns data_en low into high-impedance.
module burst_read_engine #(
    parameter int AW        = 10,
    parameter int DW        = 16,
    parameter int LAT_W     = 3,
    parameter int MIN_LAT   = 2,
    parameter int STALL_CYC = 2,
    parameter int GRP_BITS  = 3,
    parameter int BND_BITS  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce_n,
    input  logic             adv_n,
    input  logic             oe_n,
    input  logic [AW-1:0]    addr,
    input  logic [LAT_W-1:0] cfg_lat,
    input  logic             cfg_wrap,
    input  logic             cfg_rdy_en,
    output logic [DW-1:0]    data_out,
    output logic             data_en,
    output logic             rdy
);

    logic          capture;
    logic          emit;
    logic          wrap_q;
    logic          rdy_en_q;
    logic          valid_q;
    logic          drive_q;
    logic          bnd_next;
    logic [AW-1:0] ptr;
    logic [DW-1:0] word;
    logic [DW-1:0] data_q;

    bre_ctrl #(
        .LAT_W    (LAT_W),
        .MIN_LAT  (MIN_LAT),
        .STALL_CYC(STALL_CYC)
    ) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_n      (ce_n),
        .adv_n     (adv_n),
        .cfg_lat   (cfg_lat),
        .cfg_wrap  (cfg_wrap),
        .cfg_rdy_en(cfg_rdy_en),
        .bnd_next  (bnd_next),
        .capture   (capture),
        .emit      (emit),
        .wrap_q    (wrap_q),
        .rdy_en_q  (rdy_en_q),
        .valid_q   (valid_q),
        .drive_q   (drive_q)
    );

    bre_addr_gen #(
        .AW      (AW),
        .GRP_BITS(GRP_BITS),
        .BND_BITS(BND_BITS)
    ) i_addr_gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .emit    (emit),
        .wrap_q  (wrap_q),
        .addr    (addr),
        .ptr     (ptr),
        .bnd_next(bnd_next)
    );

    bre_array #(
        .AW(AW),
        .DW(DW)
    ) i_array (
        .addr(ptr),
        .word(word)
    );

    // Register the emitted word; it holds through stall cycles
    always_ff @(posedge clk) begin
        if (!rst_n)
            data_q <= '0;
        else if (emit)
            data_q <= word;
    end

    // Drive the pad-side outputs
    always_comb begin
        data_out = data_q;
        data_en  = drive_q && !oe_n && !ce_n;
        rdy      = valid_q && rdy_en_q;
    end

    AST_OE_GATES_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !data_en);                                               // R10
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!rdy && !data_en));                                   // R13

endmodule

// File: tb/test_burst_read_engine.sv
module test_burst_read_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1;
    logic        adv_n = 1'b1;
    logic        oe_n = 1'b1;
    logic [9:0]  addr = '0;
    logic [2:0]  cfg_lat = 3'd2;
    logic        cfg_wrap = 1'b0;
    logic        cfg_rdy_en = 1'b1;
    logic [15:0] data_out;
    logic        data_en;
    logic        rdy;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    burst_read_engine i_burst_read_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_n      (ce_n),
        .adv_n     (adv_n),
        .oe_n      (oe_n),
        .addr      (addr),
        .cfg_lat   (cfg_lat),
        .cfg_wrap  (cfg_wrap),
        .cfg_rdy_en(cfg_rdy_en),
        .data_out  (data_out),
        .data_en   (data_en),
        .rdy       (rdy)
    );

    // R12: content of address a
    function automatic logic [15:0] word_at(input logic [9:0] a);
        logic [31:0] p;
        p = {22'd0, a} * 32'd40503;
        return p[15:0] ^ 16'h5A5A;
    endfunction

    function automatic logic [9:0] step(input logic [9:0] a, input bit wrp);
        if (wrp) return {a[9:3], a[2:0] + 3'd1};
        return a + 10'd1;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Compare all outputs at one falling-edge sample
    task automatic sample(input string req, input bit e_rdy, input bit e_en,
                          input logic [15:0] e_data);
        check(rdy == e_rdy, req, "rdy", int'(rdy), int'(e_rdy));
        check(data_en == e_en, req, "data_en", int'(data_en), int'(e_en));
        if (e_en)
            check(data_out == e_data, req, "data_out", int'(data_out), int'(e_data));
    endtask

    // One burst from capture through n samples, with a model of latency,
    // order and stalls; optionally scrambles the config after capture (R7)
    task automatic run_burst(input logic [9:0] start, input logic [2:0] lat,
                             input bit wrp, input bit ren, input int n,
                             input string req, input bit scramble);
        int leff;
        int stall;
        logic [9:0] cur;
        leff  = (lat < 3'd2) ? 2 : int'(lat);
        cur   = start;
        stall = 0;
        ce_n = 1'b0; oe_n = 1'b0; adv_n = 1'b0; addr = start;
        cfg_lat = lat; cfg_wrap = wrp; cfg_rdy_en = ren;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (k == 0) begin
                adv_n = 1'b1;
                addr  = ~start;
                if (scramble) begin
                    cfg_lat = 3'd7 - lat; cfg_wrap = !wrp; cfg_rdy_en = !ren;
                end
            end
            if (k < leff) begin
                sample(req, 1'b0, 1'b0, 16'd0);
            end else if (k == leff) begin
                sample(req, ren, 1'b1, word_at(cur));
                stall = (!wrp && step(cur, 1'b0)[5:0] == 6'd0) ? 2 : 0;
            end else if (stall > 0) begin
                sample(req, 1'b0, 1'b1, word_at(cur));
                stall--;
            end else begin
                cur = step(cur, wrp);
                sample(req, ren, 1'b1, word_at(cur));
                stall = (!wrp && step(cur, 1'b0)[5:0] == 6'd0) ? 2 : 0;
            end
        end
    endtask

    task automatic test_reset();
        @(negedge clk);
        sample("R13", 1'b0, 1'b0, 16'd0);
    endtask

    task automatic test_latency();
        run_burst(10'd5, 3'd7, 1'b0, 1'b1, 12, "R1", 1'b0);
        run_burst(10'd17, 3'd2, 1'b0, 1'b1, 8, "R2", 1'b0);
        run_burst(10'd33, 3'd0, 1'b0, 1'b1, 6, "R1", 1'b0);
        run_burst(10'd40, 3'd1, 1'b0, 1'b1, 6, "R1", 1'b0);
    endtask

    task automatic test_linear();
        run_burst(10'd300, 3'd4, 1'b0, 1'b1, 14, "R3", 1'b0);
        run_burst(10'd1021, 3'd3, 1'b0, 1'b1, 12, "R3", 1'b0);
    endtask

    task automatic test_wrap();
        run_burst(10'd6, 3'd3, 1'b1, 1'b1, 16, "R4", 1'b0);
        run_burst(10'd62, 3'd2, 1'b1, 1'b1, 14, "R6", 1'b0);
    endtask

    task automatic test_boundary();
        run_burst(10'd60, 3'd2, 1'b0, 1'b1, 14, "R5", 1'b0);
        run_burst(10'd127, 3'd5, 1'b0, 1'b1, 12, "R5", 1'b0);
    endtask

    task automatic test_cfg_freeze();
        run_burst(10'd90, 3'd3, 1'b0, 1'b1, 12, "R7", 1'b1);
        run_burst(10'd250, 3'd6, 1'b1, 1'b0, 14, "R7", 1'b1);
    endtask

    task automatic test_abort();
        run_burst(10'd100, 3'd3, 1'b0, 1'b1, 6, "R8", 1'b0);
        ce_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            sample("R8", 1'b0, 1'b0, 16'd0);
        end
        ce_n = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            sample("R8", 1'b0, 1'b0, 16'd0);
        end
    endtask

    task automatic test_restart();
        run_burst(10'd400, 3'd4, 1'b0, 1'b1, 7, "R9", 1'b0);
        run_burst(10'd500, 3'd2, 1'b0, 1'b1, 6, "R9", 1'b0);
    endtask

    task automatic test_oe();
        run_burst(10'd200, 3'd2, 1'b0, 1'b1, 4, "R10", 1'b0);
        oe_n = 1'b1;
        #1;
        check(data_en == 1'b0, "R10", "data_en at once", int'(data_en), 0);
        @(negedge clk);
        sample("R10", 1'b1, 1'b0, 16'd0);
        oe_n = 1'b0;
        @(negedge clk);
        sample("R10", 1'b1, 1'b1, word_at(10'd203));
    endtask

    task automatic test_rdy_off();
        run_burst(10'd700, 3'd3, 1'b0, 1'b0, 10, "R11", 1'b0);
        run_burst(10'd12, 3'd2, 1'b1, 1'b0, 10, "R12", 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_latency();
        test_linear();
        test_wrap();
        test_boundary();
        test_cfg_freeze();
        test_abort();
        test_restart();
        test_oe();
        test_rdy_off();
        ce_n = 1'b1;
        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule